// File: doc/BRIEF.md
# Four-Lane Three-Wire Audio Serializer

This block drives up to four serial audio data lanes that share one bit clock and one word clock. The bit clock comes from a master clock: the block counts tick pulses from one of two master-clock sources and toggles its internal bit clock after a programmable number of ticks. Each lane shifts out a 64-bit frame, MSB first. The left 32-bit slot goes out while the word clock is low and the right slot while it is high.

Each lane has a one-sample left/right holding register that the system loads through a write strobe. A per-lane clear request empties that register. At the start of every frame, each lane copies its held samples into a frame shift register. The lane places the sample in its 32-bit slot according to that lane's own width code and justification bit. Lane enables are sampled only at frame starts, so lanes that are switched on together also start together. Per-lane mutes, a global mute and two clock-output disables act directly on the output pins.

Top module: `aud3w_serializer`

## Requirements
- R1: During and right after reset, `bclk_o` is 0, every `sdata_o` lane is 0 and `running` is 0. The slot counter rests on the last bit of a right half, so `lrck_o` reads 1 unless `lrck_off` is set.
- R2: The internal bit clock toggles after H ticks of the selected master clock, where H is the value of `div_code`. Codes 1, 2, 4 and 6 give divide-by-2, 4, 8 and 12. Code 0 behaves like code 1.
- R3: `mclk_sel` = 0 counts pulses on `mtick0`. `mclk_sel` = 1 counts pulses on `mtick1`.
- R4: Every falling edge of the bit clock advances a 64-position slot counter. `lrck_o` is low for positions 0-31 (left slot) and high for positions 32-63 (right slot). Lane data changes on the same falling edge, MSB of the frame first.
- R5: Lane width code (2 bits per lane, lane c at bits 2c+1:2c): 0 = 16 bits, 2 = 20 bits, 3 = 24 bits, 1 = reserved and treated as 16. A 16-bit sample always fills slot bits 31:16. A 20- or 24-bit sample sits at the MSB end of the slot when the lane's `ch_msb` bit is 1 and at the LSB end when it is 0. Unused slot bits are 0. Samples are taken from the low bits of the holding register.
- R6: A lane's `running` bit takes the value of its `ch_en` bit only at a frame start (slot counter wrapping to 0). A lane that is not running outputs 0.
- R7: A `buf_clr` pulse on a lane clears both of its holding registers in the next cycle. It wins over a write strobe in the same cycle and does not touch other lanes.
- R8: `ch_mute[c]` forces lane c's data to 0. `mute_all` forces every lane to 0. Neither mute alters the frame timing or the `running` bits.
- R9: `bclk_off` holds `bclk_o` at 0 and `lrck_off` holds `lrck_o` at 0. Internal timing continues while they are set.
- R10: A lane captures its holding registers only at a frame start. A write in mid-frame appears in the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mtick0 | input | 1 | Tick pulse of master clock 0 |
| mtick1 | input | 1 | Tick pulse of master clock 1 |
| mclk_sel | input | 1 | Master clock source select |
| div_code | input | 4 | Bit-clock half-period in master ticks |
| ch_en | input | 4 | Per-lane enable requests |
| ch_width | input | 8 | Per-lane width codes |
| ch_msb | input | 4 | Per-lane justification (1 = MSB end) |
| smp_we | input | 4 | Per-lane holding-register write strobes |
| smp_left | input | 96 | Left samples, 24 bits per lane |
| smp_right | input | 96 | Right samples, 24 bits per lane |
| buf_clr | input | 4 | Per-lane holding-register clear pulses |
| ch_mute | input | 4 | Per-lane mutes |
| mute_all | input | 1 | Mute for every lane |
| bclk_off | input | 1 | Bit-clock output disable |
| lrck_off | input | 1 | Word-clock output disable |
| bclk_o | output | 1 | Bit clock output |
| lrck_o | output | 1 | Word clock output |
| sdata_o | output | 4 | Serial data lanes |
| running | output | 4 | Per-lane running status |

## Verification
The assertions check the following on every cycle:
- the global mute and the bit-clock disable silence their pins;
- lanes that are not running stay quiet;
- `running` changes only on a frame start;
- the slot counter only ever steps by one.

Some behaviour only the bench's scenarios can show, using a behavioural model compared on every clock:
- the exact bit patterns for each width/justification combination;
- the four divider ratios;
- the master-clock select;
- that clears and mid-frame writes land in the right frame.

// File: rtl/aud3w_serializer.sv
module aud3w_serializer #(
  parameter int NCH = 4,
  parameter int DW  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mtick0,
  input  logic              mtick1,
  input  logic              mclk_sel,
  input  logic [DW-1:0]     div_code,
  input  logic [NCH-1:0]    ch_en,
  input  logic [2*NCH-1:0]  ch_width,
  input  logic [NCH-1:0]    ch_msb,
  input  logic [NCH-1:0]    smp_we,
  input  logic [NCH*24-1:0] smp_left,
  input  logic [NCH*24-1:0] smp_right,
  input  logic [NCH-1:0]    buf_clr,
  input  logic [NCH-1:0]    ch_mute,
  input  logic              mute_all,
  input  logic              bclk_off,
  input  logic              lrck_off,
  output logic              bclk_o,
  output logic              lrck_o,
  output logic [NCH-1:0]    sdata_o,
  output logic [NCH-1:0]    running
);
  localparam int SW    = 24;
  localparam int SLOT  = 32;
  localparam int FBITS = 2 * SLOT;
  localparam int PW    = $clog2(FBITS);

  logic [DW-1:0] tcnt, half;
  logic          bclk_q, tick, edge_hit, fall, fstart;
  logic [PW-1:0] bitpos;

  assign half     = (div_code == '0) ? DW'(1) : div_code;
  assign tick     = mclk_sel ? mtick1 : mtick0;
  assign edge_hit = tick && (tcnt >= half - DW'(1));
  assign fall     = edge_hit && bclk_q;
  assign fstart   = fall && (bitpos == PW'(FBITS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tcnt   <= '0;
      bclk_q <= 1'b0;
      bitpos <= PW'(FBITS - 1);
    end else if (tick) begin
      if (edge_hit) begin
        tcnt   <= '0;
        bclk_q <= ~bclk_q;
        if (bclk_q) bitpos <= bitpos + PW'(1);
      end else begin
        tcnt <= tcnt + DW'(1);
      end
    end
  end

  assign bclk_o = bclk_q & ~bclk_off;
  assign lrck_o = bitpos[PW-1] & ~lrck_off;

  function automatic logic [SLOT-1:0] place(input logic [SW-1:0] s, input logic [1:0] w, input logic m);
    case (w)
      2'd2:    place = m ? {s[19:0], 12'd0} : {12'd0, s[19:0]};
      2'd3:    place = m ? {s, 8'd0} : {8'd0, s};
      default: place = {s[15:0], 16'd0};
    endcase
  endfunction

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    logic [SW-1:0]    hold_l, hold_r;
    logic [FBITS-1:0] shreg;
    logic             run_q;

    always_ff @(posedge clk) begin
      if (rst || buf_clr[c]) begin
        hold_l <= '0;
        hold_r <= '0;
      end else if (smp_we[c]) begin
        hold_l <= smp_left[c*SW +: SW];
        hold_r <= smp_right[c*SW +: SW];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        shreg <= '0;
        run_q <= 1'b0;
      end else if (fall) begin
        if (fstart) begin
          shreg <= {place(hold_l, ch_width[2*c +: 2], ch_msb[c]),
                    place(hold_r, ch_width[2*c +: 2], ch_msb[c])};
          run_q <= ch_en[c];
        end else begin
          shreg <= shreg << 1;
        end
      end
    end

    assign sdata_o[c] = run_q & shreg[FBITS-1] & ~ch_mute[c] & ~mute_all;
    assign running[c] = run_q;
  end
endmodule

// File: rtl/aud3w_serializer_chk.sv
module aud3w_serializer_chk #(
  parameter int NCH = 4,
  parameter int PW  = 6
) (
  input logic           clk,
  input logic           rst,
  input logic           mute_all,
  input logic           bclk_off,
  input logic           bclk_o,
  input logic [NCH-1:0] sdata_o,
  input logic [NCH-1:0] running,
  input logic [PW-1:0]  bitpos
);
  a_r8_mute_all_silent: assert property (@(posedge clk) disable iff (rst)
    mute_all |-> (sdata_o == '0));

  a_r9_bclk_held: assert property (@(posedge clk) disable iff (rst)
    bclk_off |-> !bclk_o);

  a_r6_run_at_frame: assert property (@(posedge clk) disable iff (rst)
    (running != $past(running)) |-> (bitpos == '0));

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    ((running & sdata_o) != sdata_o) |-> 1'b0);

  a_r4_pos_step: assert property (@(posedge clk) disable iff (rst)
    (bitpos != $past(bitpos)) |-> (bitpos == PW'($past(bitpos) + 1'b1)));
endmodule

bind aud3w_serializer aud3w_serializer_chk #(.NCH(NCH), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .mute_all(mute_all), .bclk_off(bclk_off),
  .bclk_o(bclk_o), .sdata_o(sdata_o), .running(running), .bitpos(bitpos)
);

// File: tb/sim_aud3w_serializer.sv
module sim_aud3w_serializer;
  logic clk = 0, rst = 1;
  logic t0 = 1, t1 = 0, sel = 0;
  logic [3:0] div = 1, en = 0, msb = 0, we = 0, clr = 0, mute = 0;
  logic [7:0] wid = 0;
  logic [95:0] sl = 0, sr = 0;
  logic mall = 0, boff = 0, loff = 0;
  logic bclk_o, lrck_o;
  logic [3:0] sdata_o, running;

  aud3w_serializer u0 (.clk(clk), .rst(rst), .mtick0(t0), .mtick1(t1), .mclk_sel(sel),
    .div_code(div), .ch_en(en), .ch_width(wid), .ch_msb(msb), .smp_we(we),
    .smp_left(sl), .smp_right(sr), .buf_clr(clr), .ch_mute(mute), .mute_all(mall),
    .bclk_off(boff), .lrck_off(loff), .bclk_o(bclk_o), .lrck_o(lrck_o),
    .sdata_o(sdata_o), .running(running));

  always #4 clk = ~clk;
  always @(posedge clk) #2 t1 <= ~t1;

  int total = 0, bad = 0;
  bit fin = 0;
  string cur = "R1";

  int mtc, mb, mpos, hv;
  bit tk;
  logic [3:0] mrun;
  logic [23:0] ml [4];
  logic [23:0] mr [4];
  logic [63:0] mfr [4];

  function automatic logic [31:0] mk(logic [23:0] s, int wc, bit m);
    int n;
    logic [31:0] v;
    n = (wc == 2) ? 20 : ((wc == 3) ? 24 : 16);
    v = {8'd0, s} & ((32'd1 << n) - 32'd1);
    if (n == 16 || m) v = v << (32 - n);
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mtc = 0; mb = 0; mpos = 63; mrun = 0;
      for (int c = 0; c < 4; c++) begin ml[c] = 0; mr[c] = 0; mfr[c] = 0; end
    end else begin
      tk = sel ? t1 : t0;
      hv = (div == 0) ? 1 : int'(div);
      if (tk) begin
        if (mtc >= hv - 1) begin
          mtc = 0;
          if (mb == 1) begin
            mpos = (mpos + 1) % 64;
            if (mpos == 0)
              for (int c = 0; c < 4; c++) begin
                mrun[c] = en[c];
                mfr[c] = {mk(ml[c], int'(wid[2*c +: 2]), msb[c]), mk(mr[c], int'(wid[2*c +: 2]), msb[c])};
              end
          end
          mb = 1 - mb;
        end else mtc = mtc + 1;
      end
      for (int c = 0; c < 4; c++)
        if (clr[c]) begin ml[c] = 0; mr[c] = 0; end
        else if (we[c]) begin ml[c] = sl[c*24 +: 24]; mr[c] = sr[c*24 +: 24]; end
    end
  end

  task automatic chk(string what, logic [3:0] got, logic [3:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", cur, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (!fin) begin
    chk("bclk_o", {3'd0, bclk_o}, {3'd0, (mb == 1) & !boff});
    chk("lrck_o", {3'd0, lrck_o}, {3'd0, (mpos >= 32) & !loff});
    chk("running", running, mrun);
    for (int c = 0; c < 4; c++)
      chk($sformatf("sdata_o[%0d]", c), {3'd0, sdata_o[c]},
          {3'd0, mrun[c] & !mute[c] & !mall & mfr[c][63 - mpos]});
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic load(int c, logic [23:0] l, logic [23:0] r);
    sl[c*24 +: 24] = l; sr[c*24 +: 24] = r; we[c] = 1;
    cyc(1);
    we[c] = 0;
  endtask

  initial begin
    #10000000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(6);
    cur = "R1";
    rst = 0;
    cur = "R4";
    load(0, 24'hA5C3F1, 24'h5A3C0F);
    load(1, 24'h123456, 24'hFEDCBA);
    load(2, 24'hF0F0F0, 24'h0F0F0F);
    load(3, 24'h8001FF, 24'h7FFE01);
    cyc(200);
    cur = "R6"; en = 4'b1111; cyc(37); en = 4'b1111; cyc(300);
    cur = "R5"; wid = {2'd3, 2'd2, 2'd2, 2'd0}; msb = 4'b0010; cyc(300);
    msb = 4'b1111; wid = {2'd3, 2'd3, 2'd2, 2'd1}; cyc(300);
    cur = "R10";
    cyc(13); load(0, 24'h00BEEF, 24'hC0FFEE);
    cyc(51); load(3, 24'h13579B, 24'h2468AC);
    cyc(77); load(1, 24'hFFFFFF, 24'h000001);
    cyc(250);
    cur = "R7";
    sl[48 +: 24] = 24'hABCDEF; sr[48 +: 24] = 24'h111111; we[2] = 1; clr[2] = 1;
    cyc(1); we[2] = 0; clr[2] = 0;
    cyc(150); clr[1] = 1; cyc(1); clr[1] = 0; cyc(300);
    cur = "R8"; mute = 4'b0010; cyc(200); mall = 1; cyc(200); mute = 0; mall = 0; cyc(50);
    cur = "R6"; en = 4'b1001; cyc(200); en = 4'b0110; cyc(99); en = 4'b1111; cyc(300);
    cur = "R2"; div = 2; cyc(800); div = 4; cyc(1600); div = 6; cyc(2000);
    div = 0; cyc(300); div = 1; cyc(100);
    cur = "R3"; sel = 1; cyc(600); sel = 0; cyc(100);
    cur = "R9"; boff = 1; cyc(200); loff = 1; cyc(200); boff = 0; cyc(100); loff = 0; cyc(100);
    fin = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule